// File: doc/BRIEF.md
# Shared Multi-Channel Decimating Channel Filter

This block is the narrow-band low-pass stage of a multi-channel receiver. Each channel's dedicated tuning stages have already lowered the sample rate far below the clock rate. That gap lets one multiply-accumulate datapath filter the in-phase and quadrature streams of every channel in turn. A single input strobe delivers one complex sample for every channel at once. Each channel keeps its own I and Q history rings. A programmable decimation ratio decides which accepted strobes start a filtering pass.

During a pass, a small scheduler visits channels in ascending order. For each channel it spends one clock per tap on I and then one clock per tap on Q. It then emits one complex result tagged with the channel index. A strobe that arrives while a pass is running cannot be stored safely, so it is dropped and flagged.

The scheduler has three states. `ST_IDLE` waits for an accepted strobe that completes a decimation period and then moves to `ST_RUN_I`. `ST_RUN_I` steps through all taps of the current channel's I ring and on its last tap moves to `ST_RUN_Q`. `ST_RUN_Q` steps through the Q ring and on its last tap emits the result. It then moves to `ST_RUN_I` for the next channel, or back to `ST_IDLE` after the highest channel.

Top module: `shared_chan_fir`

## Requirements
- R1: While and directly after reset, `out_valid`, `overrun`, `out_ch`, `out_i` and `out_q` are all zero, and every history ring holds zeros.
- R2: Each output value is round(sum over k of w[k]·x[n−k] / 2^17). Here x[n] is the newest stored sample of that channel and path, and x[n−k] is the sample stored k accepted strobes earlier. Rounding adds 2^16 and then shifts right arithmetically by 17. The weights are w[k] = min(k+1, NTAP−k) · floor(2^17 / ((NTAP/2)·(NTAP/2+1))), a symmetric triangle. NTAP is an even power of two.
- R3: The I and Q paths of each channel use the same weights but separate histories. The 48-bit accumulation never produces a rounded result outside the signed 16-bit range.
- R4: An accepted strobe starts a pass when it is the D-th accepted strobe since the previous pass start (or since reset). D is `decim`, and a `decim` of 0 acts as 1.
- R5: A pass serves channels 0, 1, …, NCH−1 in order. The result for channel c is valid in the cycle that follows the edge (c+1)·2·NTAP clock edges after the edge that accepted the starting strobe.
- R6: `out_valid` is high for exactly one cycle per channel per pass.
- R7: A strobe sampled while a pass is running is discarded: its samples are not stored and it does not count towards decimation. `overrun` is high for the one cycle after that edge. A strobe on the first edge after the last channel's result is accepted.
- R8: Channel c's input sample occupies bits [16c+15:16c] of `in_i` and `in_q`, and `out_ch` always holds an index below NCH while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decim | input | DECIM_W | Decimation ratio in accepted strobes (0 acts as 1) |
| in_valid | input | 1 | Strobe: one new sample for every channel |
| in_i | input | NCH·16 | Per-channel in-phase samples, channel c in lane c |
| in_q | input | NCH·16 | Per-channel quadrature samples, channel c in lane c |
| out_valid | output | 1 | One-cycle result strobe |
| out_ch | output | max(1,log2 NCH) | Channel index of the result |
| out_i | output | 16 | Filtered in-phase result |
| out_q | output | 16 | Filtered quadrature result |
| overrun | output | 1 | One-cycle pulse: a strobe was dropped |

## Verification
A corrupted write pointer or ring entry shows up in the first result of the next pass. It appears as a wrong value on the I or Q output of the affected channel at a known cycle, because every earlier sample is weighted in the sum. A tap counter or channel counter that slips moves `out_valid` off its slot (c+1)·2·NTAP edges after the strobe, or breaks the ascending channel order, within one pass. A wrong decimation count or busy flag changes which strobe starts a pass or raises `overrun`. Either one differs from the reference on the very next strobe.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int SAMP_W = 16;
    localparam int COEF_W = 18;
    localparam int ACC_W  = 48;
    localparam int FRAC   = 17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN_I,
        ST_RUN_Q
    } sched_state_t;

    // Symmetric triangular low-pass weight for tap k of ntap (ntap even).
    function automatic logic signed [COEF_W-1:0] tap_weight(input int k, input int ntap);
        int half;
        int unit;
        int height;
        half   = ntap / 2;
        unit   = (1 << FRAC) / (half * (half + 1));
        height = (k + 1 < ntap - k) ? (k + 1) : (ntap - k);
        return COEF_W'(height * unit);
    endfunction
endpackage

// File: rtl/scf_hist.sv
module scf_hist #(
    parameter int NCH  = 4,
    parameter int NTAP = 32,
    parameter int SW   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW  = $clog2(NTAP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [NCH*SW-1:0]     wr_i,
    input  logic [NCH*SW-1:0]     wr_q,
    input  logic [CHW-1:0]        rd_ch,
    input  logic                  rd_q,
    input  logic [TW-1:0]         rd_tap,
    output logic signed [SW-1:0]  rd_data
);
    logic [TW-1:0]        wp;
    logic [TW-1:0]        rd_idx;
    logic signed [SW-1:0] lane_i [NCH];
    logic signed [SW-1:0] lane_q [NCH];

    // Newest sample sits one slot behind the write pointer.
    assign rd_idx = wp - TW'(1) - rd_tap;

    always_ff @(posedge clk) begin
        if (!rst_n)  wp <= '0;
        else if (we) wp <= wp + TW'(1);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic signed [SW-1:0] ring_i [NTAP];
        logic signed [SW-1:0] ring_q [NTAP];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int t = 0; t < NTAP; t++) begin
                    ring_i[t] <= '0;
                    ring_q[t] <= '0;
                end
            end else if (we) begin
                ring_i[wp] <= wr_i[c*SW +: SW];
                ring_q[wp] <= wr_q[c*SW +: SW];
            end
        end

        assign lane_i[c] = ring_i[rd_idx];
        assign lane_q[c] = ring_q[rd_idx];
    end

    assign rd_data = rd_q ? lane_q[rd_ch] : lane_i[rd_ch];
endmodule

// File: rtl/scf_mac.sv
module scf_mac
    import scf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic                     last,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SAMP_W-1:0] samp,
    output logic signed [SAMP_W-1:0] rounded
);
    localparam int PW = COEF_W + SAMP_W;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (FRAC - 1);

    logic signed [PW-1:0]    prod_n;
    logic signed [ACC_W-1:0] prod_w;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] shifted;

    assign prod_n  = coef * samp;
    assign prod_w  = {{(ACC_W-PW){prod_n[PW-1]}}, prod_n};
    assign total   = (first ? '0 : acc) + prod_w;
    assign shifted = (total + HALF_LSB) >>> FRAC;
    assign rounded = shifted[SAMP_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= total;
    end

    // R3: a finished sum, once rounded, fits the 16-bit output.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last) |-> ((shifted <= 48'sd32767) && (shifted >= -48'sd32768)));
endmodule

// File: rtl/shared_chan_fir.sv
module shared_chan_fir
    import scf_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int NTAP    = 32,
    parameter int DECIM_W = 8,
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW     = $clog2(NTAP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DECIM_W-1:0]    decim,
    input  logic                  in_valid,
    input  logic [NCH*16-1:0]     in_i,
    input  logic [NCH*16-1:0]     in_q,
    output logic                  out_valid,
    output logic [CHW-1:0]        out_ch,
    output logic [15:0]           out_i,
    output logic [15:0]           out_q,
    output logic                  overrun
);
    sched_state_t state, nxt;

    logic [CHW-1:0]            ch_idx;
    logic [TW-1:0]             tap;
    logic [DECIM_W-1:0]        dcnt;
    logic [DECIM_W-1:0]        eff_decim;
    logic signed [SAMP_W-1:0]  i_hold;
    logic signed [SAMP_W-1:0]  samp;
    logic signed [SAMP_W-1:0]  rounded;
    logic signed [COEF_W-1:0]  coef_tab [NTAP];
    logic busy, accept, due, last_tap, last_ch;

    for (genvar g = 0; g < NTAP; g++) begin : g_coef
        assign coef_tab[g] = tap_weight(g, NTAP);
    end

    assign busy      = (state != ST_IDLE);
    assign accept    = in_valid && !busy;
    assign eff_decim = (decim == '0) ? DECIM_W'(1) : decim;
    assign due       = accept && (({1'b0, dcnt} + (DECIM_W+1)'(1)) >= {1'b0, eff_decim});
    assign last_tap  = (tap == TW'(NTAP - 1));
    assign last_ch   = (ch_idx == CHW'(NCH - 1));

    scf_hist #(.NCH(NCH), .NTAP(NTAP), .SW(SAMP_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept),
        .wr_i    (in_i),
        .wr_q    (in_q),
        .rd_ch   (ch_idx),
        .rd_q    (state == ST_RUN_Q),
        .rd_tap  (tap),
        .rd_data (samp)
    );

    scf_mac u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (busy),
        .first   (tap == '0),
        .last    (last_tap),
        .coef    (coef_tab[tap]),
        .samp    (samp),
        .rounded (rounded)
    );

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (due)      nxt = ST_RUN_I;
            ST_RUN_I: if (last_tap) nxt = ST_RUN_Q;
            ST_RUN_Q: if (last_tap) nxt = last_ch ? ST_IDLE : ST_RUN_I;
            default:                nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Counters, holding register and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_idx    <= '0;
            tap       <= '0;
            dcnt      <= '0;
            i_hold    <= '0;
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_i     <= '0;
            out_q     <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            overrun   <= in_valid && busy;
            if (accept) dcnt <= due ? '0 : dcnt + DECIM_W'(1);
            unique case (state)
                ST_IDLE: begin
                    tap    <= '0;
                    ch_idx <= '0;
                end
                ST_RUN_I: begin
                    tap <= last_tap ? '0 : tap + TW'(1);
                    if (last_tap) i_hold <= rounded;
                end
                ST_RUN_Q: begin
                    tap <= last_tap ? '0 : tap + TW'(1);
                    if (last_tap) begin
                        out_valid <= 1'b1;
                        out_ch    <= ch_idx;
                        out_i     <= i_hold;
                        out_q     <= rounded;
                        ch_idx    <= last_ch ? '0 : ch_idx + CHW'(1);
                    end
                end
                default: tap <= '0;
            endcase
        end
    end

    // Checker state: index of the previous result.
    logic [CHW-1:0] prev_ch;
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_ch <= '0;
        else if (out_valid) prev_ch <= out_ch;
    end

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_ch_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ch != '0) |-> (out_ch == prev_ch + CHW'(1)));

    assert_ch_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ch <= CHW'(NCH - 1)));

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(in_valid));
endmodule

// File: tb/shared_chan_fir_bench.sv
module shared_chan_fir_bench;
    localparam int NCH  = 4;
    localparam int NTAP = 32;
    localparam int PASS = NCH * 2 * NTAP;
    localparam int CHW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        decim = 8'd1;
    logic              in_valid = 1'b0;
    logic [NCH*16-1:0] in_i = '0;
    logic [NCH*16-1:0] in_q = '0;
    logic              out_valid;
    logic [CHW-1:0]    out_ch;
    logic [15:0]       out_i;
    logic [15:0]       out_q;
    logic              overrun;

    always #5 clk = ~clk;

    shared_chan_fir u_shared_chan_fir (
        .clk(clk), .rst_n(rst_n), .decim(decim), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ch(out_ch),
        .out_i(out_i), .out_q(out_q), .overrun(overrun)
    );

    typedef struct { int cyc; int ch; int vi; int vq; } exp_t;

    int   checks = 0, fails = 0, cyc = 0;
    bit   done = 0;
    int   hi [NCH][NTAP];
    int   hq [NCH][NTAP];
    int   wcoef [NTAP];
    exp_t expq [$];
    int   busy_left = 0, dcnt = 0, pushed = 0, seen = 0;
    bit   exp_ovr = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int filt(input int c, input bit q);
        longint acc = 0;
        for (int k = 0; k < NTAP; k++)
            acc += longint'(wcoef[k]) * longint'(q ? hq[c][k] : hi[c][k]);
        return int'((acc + 64'sd65536) >>> 17);
    endfunction

    // Behavioural model of one clock edge.
    task automatic model_edge();
        bit ov;
        int eff;
        ov = in_valid && (busy_left > 0);
        exp_ovr = ov;
        if (busy_left > 0) busy_left--;
        if (in_valid && !ov) begin
            for (int c = 0; c < NCH; c++) begin
                for (int k = NTAP - 1; k > 0; k--) begin
                    hi[c][k] = hi[c][k-1];
                    hq[c][k] = hq[c][k-1];
                end
                hi[c][0] = int'($signed(in_i[c*16 +: 16]));
                hq[c][0] = int'($signed(in_q[c*16 +: 16]));
            end
            dcnt++;
            eff = (decim == 0) ? 1 : int'(decim);
            if (dcnt >= eff) begin
                dcnt = 0;
                for (int c = 0; c < NCH; c++) begin
                    exp_t e;
                    e.cyc = cyc + (c + 1) * 2 * NTAP;
                    e.ch = c;
                    e.vi = filt(c, 1'b0);
                    e.vq = filt(c, 1'b1);
                    expq.push_back(e);
                    pushed++;
                end
                busy_left = PASS;
            end
        end
    endtask

    task automatic compare();
        bit want;
        want = (expq.size() > 0) && (expq[0].cyc == cyc);
        check(out_valid == want, "R4/R5/R6 out_valid", int'(out_valid), int'(want));
        if (want && out_valid) begin
            seen++;
            check(int'(out_ch) == expq[0].ch, "R5/R8 out_ch", int'(out_ch), expq[0].ch);
            check(int'($signed(out_i)) == expq[0].vi, "R2 out_i", int'($signed(out_i)), expq[0].vi);
            check(int'($signed(out_q)) == expq[0].vq, "R3 out_q", int'($signed(out_q)), expq[0].vq);
        end
        if (want) void'(expq.pop_front());
        check(overrun == exp_ovr, "R7 overrun", int'(overrun), int'(exp_ovr));
    endtask

    task automatic step(input bit v);
        in_valid = v;
        @(posedge clk);
        cyc++;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    function automatic logic [15:0] rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    task automatic load_random();
        for (int c = 0; c < NCH; c++) begin
            in_i[c*16 +: 16] = rnd16();
            in_q[c*16 +: 16] = rnd16();
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NTAP; k++)
            wcoef[k] = ((k + 1 < NTAP - k) ? k + 1 : NTAP - k) * ((1 << 17) / ((NTAP/2) * (NTAP/2 + 1)));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        check(out_i == 16'd0 && out_q == 16'd0, "R1 out_i/out_q", int'(out_i) + int'(out_q), 0);
        check(out_ch == '0, "R1 out_ch", int'(out_ch), 0);
        rst_n = 1'b1;

        // R2 R8: impulse into channel 0 I only, decimation 1
        decim = 8'd1;
        in_i = '0; in_q = '0;
        in_i[15:0] = 16'd1000;
        step(1'b1);
        in_i = '0;
        repeat (NTAP + 2) begin
            repeat (PASS) step(1'b0);
            step(1'b1);
        end
        repeat (PASS + 4) step(1'b0);

        // Ramp per lane, back-to-back at the pass boundary
        for (int n = 0; n < 12; n++) begin
            for (int c = 0; c < NCH; c++) begin
                in_i[c*16 +: 16] = 16'(n * 300 + c * 50);
                in_q[c*16 +: 16] = 16'(-(n * 200) - c * 70);
            end
            step(1'b1);
            repeat (PASS) step(1'b0);
        end

        // R7: strobe on the last busy edge is dropped, the next is taken
        load_random();
        step(1'b1);
        repeat (PASS - 1) step(1'b0);
        load_random();
        step(1'b1);
        load_random();
        step(1'b1);
        repeat (PASS + 4) step(1'b0);

        // R4: decimation by 3 with mixed spacing
        decim = 8'd3;
        for (int n = 0; n < 30; n++) begin
            load_random();
            step(1'b1);
            repeat ((n % 3 == 2) ? PASS : 5) step(1'b0);
        end

        // R3 R7: full-scale extremes, decimation 0 acts as 1, continuous strobes
        decim = 8'd0;
        for (int n = 0; n < 3 * PASS; n++) begin
            for (int c = 0; c < NCH; c++) begin
                in_i[c*16 +: 16] = (n % 2 == 0) ? 16'h8000 : 16'h8000;
                in_q[c*16 +: 16] = 16'h7FFF;
            end
            step(1'b1);
        end
        repeat (PASS + 4) step(1'b0);

        // Random data, decimation 2, strobes every third cycle
        decim = 8'd2;
        for (int n = 0; n < 400; n++) begin
            load_random();
            step(1'b1);
            repeat (2) step(1'b0);
        end
        repeat (PASS + 8) step(1'b0);

        // R4: every scheduled result appeared
        check(seen == pushed, "R4 result count", seen, pushed);
        check(expq.size() == 0, "R5 pending results", expq.size(), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule